// File: doc/BRIEF.md
# Keyboard and Display Port Adapter

This block sits on a small processor bus and connects two byte-wide peripheral ports. Port A takes characters from an ASCII keyboard. The keyboard presents a 7-bit code and a strobe pulse. Port B sends characters to a display. A data-available output and a ready-to-accept input pace the transfer. The processor reaches six registers through a 2-bit register select. These are a direction register, a peripheral register and a control register for each port. The data register address of each port shows either the direction register or the peripheral register, and a bit in that port's control register picks which one.

Software sets the block up in four steps after reset:
1. With the select bit low, write the direction registers.
2. Set the select bit to reach the peripheral registers.
3. Poll bit 7 of control A until it shows a keystroke, then read peripheral A. The read hands over the character and clears the flag.
4. Before writing a new character to peripheral B, check that bit 7 of peripheral B reads low. That bit carries data-available back as an input pin.

Both handshake inputs pass through a synchroniser and an edge detector whose polarity is programmable. All state changes on the falling edge of the phase-2 clock.

Top module: `kbd_disp_adapter`

## Requirements
- R1: After reset, every control register, direction register and output latch is zero, `dsp_avail` is 0 and `pb_dir` is 0x00.
- R2: Register select 01 reaches control A and 11 reaches control B. Select 00 reaches peripheral A when control-A bit 2 is 1 and direction A when it is 0. Select 10 does the same for port B under control-B bit 2.
- R3: A control register reads back the written value in bits 5..0. Bit 6 reads 0 and bit 7 is the handshake flag. Writes to bits 7 and 6 are ignored.
- R4: A peripheral register read returns, bit by bit, the output latch where the direction bit is 1 and the pin value where it is 0. The pin value of port A is {0, latched keyboard code}. The pin value of port B is {`dsp_avail`, `pb_in`}.
- R5: The active edge of `kbd_strobe` loads `kbd_char` into the keyboard latch and sets flag A. Control bit 1 selects the active edge: 1 selects rising and 0 selects falling. The other edge has no effect.
- R6: A handshake flag stays set until the processor reads the matching peripheral register, and only that read clears it. Holding the strobe high sets the flag once.
- R7: A write to peripheral B sets `dsp_avail`. The active edge of `dsp_ready`, selected by control-B bit 1, clears `dsp_avail` and sets flag B. When a write and an edge fall on the same cycle, the write wins.
- R8: `pb_dir` equals direction B, and `pb_out` equals output latch B masked by direction B.
- R9: Writes take effect on the falling edge of `phi2` only while `cs` is 1 and `rw` is 0. `dout` is 0 whenever `cs` is 0 or `rw` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Phase-2 bus clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 2 | Register select |
| din | input | W | Write data from the processor |
| dout | output | W | Read data to the processor |
| kbd_char | input | W-1 | Keyboard character code |
| kbd_strobe | input | 1 | Keyboard strobe, asynchronous |
| pb_in | input | W-1 | Display-side input pins, bits W-2..0 |
| pb_out | output | W | Display data, driven bits only |
| pb_dir | output | W | Display port direction, 1 = output |
| dsp_avail | output | 1 | Character waiting for the display |
| dsp_ready | input | 1 | Display ready-to-accept, asynchronous |

## Verification
The bench holds the keyboard strobe high long after a read has cleared the flag. A level-sensitive or unsynchronised detector would set the flag again. It also checks that reading a control register leaves the flag set, and that the non-selected strobe edge does nothing. A design that cleared the flag on any read, or that ignored the polarity bit, would show a wrong bit 7. Port reads use mixed direction masks, where swapping latch and pin selection gives a different byte. The bench also checks that the select bit really switches between the direction and peripheral registers, and that a bus access with chip select low changes nothing.

// File: rtl/kda_pkg.sv
package kda_pkg;
   // register select encodings
   typedef enum logic [1:0] {
      RS_A_DATA = 2'b00,
      RS_A_CTRL = 2'b01,
      RS_B_DATA = 2'b10,
      RS_B_CTRL = 2'b11
   } kda_rsel_e;

   // control register bit positions
   localparam int CB_EDGE = 1;   // 1 = rising edge active
   localparam int CB_SEL  = 2;   // 1 = peripheral register visible
endpackage

// File: rtl/kda_hs_sync.sv
module kda_hs_sync #(
   parameter int STAGES = 2
) (
   input  logic phi2,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic edge_o
);
   localparam int SH_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("kda_hs_sync: STAGES must be at least 2");
   end

   logic [SH_W-1:0] sh_q;

   always_ff @(negedge phi2 or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], pin};
   end

   // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
   assign edge_o = rise_sel ? ( sh_q[STAGES-1] & ~sh_q[STAGES])
                            : (~sh_q[STAGES-1] &  sh_q[STAGES]);
endmodule

// File: rtl/kda_port.sv
module kda_port
   import kda_pkg::*;
#(
   parameter int W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         phi2,
   input  logic         rst_n,
   input  logic         wr_ctrl,
   input  logic         wr_dir,
   input  logic         wr_out,
   input  logic         rd_per,
   input  logic [W-1:0] wdata,
   input  logic         hs_pin,
   output logic [W-1:0] ctrl_o,
   output logic [W-1:0] dir_o,
   output logic [W-1:0] out_o,
   output logic         edge_o
);
   localparam int CS_W = W - 2;

   logic [CS_W-1:0] ctrl_q;
   logic [W-1:0]    dir_q;
   logic [W-1:0]    out_q;
   logic            flag_q;
   logic            hs_edge;

   kda_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .phi2     (phi2),
      .rst_n    (rst_n),
      .pin      (hs_pin),
      .rise_sel (ctrl_q[CB_EDGE]),
      .edge_o   (hs_edge)
   );

   always_ff @(negedge phi2 or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dir_q  <= '0;
         out_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[CS_W-1:0];
         if (wr_dir)  dir_q  <= wdata;
         if (wr_out)  out_q  <= wdata;
      end
   end

   // a new edge beats a clearing read in the same cycle
   always_ff @(negedge phi2 or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (hs_edge) flag_q <= 1'b1;
      else if (rd_per)  flag_q <= 1'b0;
   end

   assign ctrl_o = {flag_q, 1'b0, ctrl_q};
   assign dir_o  = dir_q;
   assign out_o  = out_q;
   assign edge_o = hs_edge;
endmodule

// File: rtl/kbd_disp_adapter.sv
module kbd_disp_adapter
   import kda_pkg::*;
#(
   parameter int W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         phi2,
   input  logic         rst_n,
   input  logic         cs,
   input  logic         rw,
   input  logic [1:0]   rs,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   input  logic [W-2:0] kbd_char,
   input  logic         kbd_strobe,
   input  logic [W-2:0] pb_in,
   output logic [W-1:0] pb_out,
   output logic [W-1:0] pb_dir,
   output logic         dsp_avail,
   input  logic         dsp_ready
);
   localparam int NP = 2;

   if (W < 4) begin : g_bad_width
      $error("kbd_disp_adapter: W must be at least 4");
   end

   logic          wr_en, rd_en;
   logic [W-1:0]  ctrl_w [NP];
   logic [W-1:0]  dir_w  [NP];
   logic [W-1:0]  out_w  [NP];
   logic [W-1:0]  pin_w  [NP];
   logic [W-1:0]  perv_w [NP];
   logic [NP-1:0] edge_w, hs_pin_w, wr_out_w;
   logic [W-2:0]  kbd_q;
   logic          avail_q;

   assign wr_en    = cs & ~rw;
   assign rd_en    = cs &  rw;
   assign hs_pin_w = {dsp_ready, kbd_strobe};
   assign pin_w[0] = {1'b0, kbd_q};
   assign pin_w[1] = {avail_q, pb_in};

   for (genvar gp = 0; gp < NP; gp++) begin : g_port
      logic hit, data_hit, peri;
      assign hit      = (rs[1] == 1'(gp));
      assign data_hit = hit & ~rs[0];
      assign peri     = ctrl_w[gp][CB_SEL];
      assign wr_out_w[gp] = wr_en & data_hit & peri;

      kda_port #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_port (
         .phi2    (phi2),
         .rst_n   (rst_n),
         .wr_ctrl (wr_en & hit & rs[0]),
         .wr_dir  (wr_en & data_hit & ~peri),
         .wr_out  (wr_out_w[gp]),
         .rd_per  (rd_en & data_hit & peri),
         .wdata   (din),
         .hs_pin  (hs_pin_w[gp]),
         .ctrl_o  (ctrl_w[gp]),
         .dir_o   (dir_w[gp]),
         .out_o   (out_w[gp]),
         .edge_o  (edge_w[gp])
      );

      assign perv_w[gp] = (dir_w[gp] & out_w[gp]) | (~dir_w[gp] & pin_w[gp]);
   end

   // keyboard code captured on the active strobe edge
   always_ff @(negedge phi2 or negedge rst_n) begin
      if (!rst_n)         kbd_q <= '0;
      else if (edge_w[0]) kbd_q <= kbd_char;
   end

   // display handshake: processor write raises, ready edge drops
   always_ff @(negedge phi2 or negedge rst_n) begin
      if (!rst_n)           avail_q <= 1'b0;
      else if (wr_out_w[1]) avail_q <= 1'b1;
      else if (edge_w[1])   avail_q <= 1'b0;
   end

   always_comb begin
      dout = '0;
      if (rd_en) begin
         if (rs[0])                      dout = ctrl_w[rs[1]];
         else if (ctrl_w[rs[1]][CB_SEL]) dout = perv_w[rs[1]];
         else                            dout = dir_w[rs[1]];
      end
   end

   assign pb_out    = out_w[1] & dir_w[1];
   assign pb_dir    = dir_w[1];
   assign dsp_avail = avail_q;
endmodule

// File: rtl/kda_checker.sv
module kda_checker
   import kda_pkg::*;
#(
   parameter int W = 8
) (
   input logic         phi2,
   input logic         rst_n,
   input logic         cs,
   input logic         rw,
   input logic [1:0]   rs,
   input logic [W-1:0] dout,
   input logic [W-1:0] pb_dir,
   input logic         dsp_avail,
   input logic [W-1:0] ctrl_a,
   input logic [W-1:0] ctrl_b
);
   // R7: a peripheral-B write leaves data-available set
   a_r7_avail_on_write: assert property (@(negedge phi2) disable iff (!rst_n)
      (cs && !rw && rs == RS_B_DATA && ctrl_b[CB_SEL]) |=> dsp_avail);

   // R9: read data is quiet without a selected read
   a_r9_idle_bus: assert property (@(negedge phi2) disable iff (!rst_n)
      !(cs && rw) |-> (dout == '0));

   // R9: direction B only moves on a bus write
   a_r9_dir_needs_write: assert property (@(negedge phi2) disable iff (!rst_n)
      !(cs && !rw) |=> $stable(pb_dir));

   // R6: flag A survives every cycle without a peripheral-A read
   a_r6_flag_sticky: assert property (@(negedge phi2) disable iff (!rst_n)
      (ctrl_a[W-1] && !(cs && rw && rs == RS_A_DATA && ctrl_a[CB_SEL])) |=> ctrl_a[W-1]);

   // R3: control reads show bit 6 as zero
   a_r3_ctrl_bit6: assert property (@(negedge phi2) disable iff (!rst_n)
      (cs && rw && rs[0]) |-> !dout[W-2]);
endmodule

bind kbd_disp_adapter kda_checker #(.W(W)) u_chk (
   .phi2      (phi2),
   .rst_n     (rst_n),
   .cs        (cs),
   .rw        (rw),
   .rs        (rs),
   .dout      (dout),
   .pb_dir    (pb_dir),
   .dsp_avail (dsp_avail),
   .ctrl_a    (ctrl_w[0]),
   .ctrl_b    (ctrl_w[1])
);

// File: tb/kbd_disp_adapter_test.sv
module kbd_disp_adapter_test;
   logic       phi2 = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, rw = 1'b1;
   logic [1:0] rs = 2'b00;
   logic [7:0] din = 8'h00;
   logic [7:0] dout, pb_out, pb_dir;
   logic [6:0] kbd_char = 7'h00, pb_in = 7'h00;
   logic       kbd_strobe = 1'b0, dsp_ready = 1'b0, dsp_avail;
   int         n_cmp = 0, n_bad = 0;
   bit         done = 1'b0;

   always #5 phi2 = ~phi2;

   kbd_disp_adapter uut (
      .phi2(phi2), .rst_n(rst_n), .cs(cs), .rw(rw), .rs(rs), .din(din), .dout(dout),
      .kbd_char(kbd_char), .kbd_strobe(kbd_strobe), .pb_in(pb_in), .pb_out(pb_out),
      .pb_dir(pb_dir), .dsp_avail(dsp_avail), .dsp_ready(dsp_ready));

   // vector: [22] read, [21:20] select, [19:12] write data, [11:4] expected, [3:0] requirement
   localparam int NV = 18;
   localparam logic [22:0] VEC [NV] = '{
      {1'b1, 2'b01, 8'h00, 8'h00, 4'd1},   // R1 control A
      {1'b1, 2'b11, 8'h00, 8'h00, 4'd1},   // R1 control B
      {1'b1, 2'b00, 8'h00, 8'h00, 4'd1},   // R1 direction A
      {1'b1, 2'b10, 8'h00, 8'h00, 4'd1},   // R1 direction B
      {1'b0, 2'b10, 8'h7F, 8'h00, 4'd2},
      {1'b1, 2'b10, 8'h00, 8'h7F, 4'd2},   // R2 direction B visible
      {1'b0, 2'b01, 8'hFF, 8'h00, 4'd3},
      {1'b1, 2'b01, 8'h00, 8'h3F, 4'd3},   // R3 bits 7,6 not writable
      {1'b0, 2'b01, 8'h06, 8'h00, 4'd3},
      {1'b1, 2'b01, 8'h00, 8'h06, 4'd3},
      {1'b0, 2'b11, 8'h06, 8'h00, 4'd2},
      {1'b1, 2'b11, 8'h00, 8'h06, 4'd2},   // R2 control B
      {1'b1, 2'b10, 8'h00, 8'h00, 4'd4},   // R4 peripheral B now visible
      {1'b0, 2'b10, 8'h41, 8'h00, 4'd7},
      {1'b1, 2'b10, 8'h00, 8'hC1, 4'd7},   // R7 avail seen on bit 7
      {1'b1, 2'b00, 8'h00, 8'h00, 4'd4},   // R4 port A all inputs
      {1'b0, 2'b00, 8'h55, 8'h00, 4'd4},
      {1'b1, 2'b00, 8'h00, 8'h00, 4'd4}    // R4 latch hidden on inputs
   };

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: got %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge phi2); #1;
      cs = 1'b1; rw = 1'b0; rs = a; din = d;
      @(posedge phi2); #1;
      cs = 1'b0; rw = 1'b1;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input int req, input string what);
      @(posedge phi2); #1;
      cs = 1'b1; rw = 1'b1; rs = a;
      #2 chk(dout, exp, req, what);
      @(posedge phi2); #1;
      cs = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge phi2);
      #1;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge phi2);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
      end
   end

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);
      chk(pb_dir, 8'h00, 1, "pb_dir after reset");               // R1
      chk({7'h0, dsp_avail}, 8'h00, 1, "avail after reset");      // R1

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][22]) rd(VEC[i][21:20], VEC[i][11:4], int'(VEC[i][3:0]), "vector read");
         else            wr(VEC[i][21:20], VEC[i][19:12]);
      end

      // R8 display pins
      chk(pb_dir, 8'h7F, 8, "pb_dir");
      chk(pb_out, 8'h41, 8, "pb_out");
      chk({7'h0, dsp_avail}, 8'h01, 7, "avail after write");      // R7

      // R7 ready rising edge takes the character
      dsp_ready = 1'b1;
      idle(5);
      chk({7'h0, dsp_avail}, 8'h00, 7, "avail after ready");
      rd(2'b11, 8'h86, 7, "flag B set");
      rd(2'b11, 8'h86, 6, "control read keeps flag B");           // R6
      rd(2'b10, 8'h41, 4, "bit 7 low after take");                // R4
      rd(2'b11, 8'h06, 6, "flag B cleared by data read");         // R6
      dsp_ready = 1'b0;
      idle(5);

      // R5 keyboard strobe, rising edge selected
      kbd_char = 7'h4A;
      kbd_strobe = 1'b1;
      idle(5);
      rd(2'b01, 8'h86, 5, "flag A on strobe");
      rd(2'b01, 8'h86, 6, "control read keeps flag A");
      rd(2'b00, 8'h4A, 5, "keyboard code");
      rd(2'b01, 8'h06, 6, "flag A cleared");
      idle(5);
      rd(2'b01, 8'h06, 6, "held strobe sets once");               // R6
      kbd_strobe = 1'b0;
      idle(5);
      rd(2'b01, 8'h06, 5, "falling edge ignored when rising set");

      // R5 falling edge selected
      wr(2'b01, 8'h04);
      kbd_strobe = 1'b1;
      idle(5);
      rd(2'b01, 8'h04, 5, "rising edge ignored when falling set");
      kbd_char = 7'h33;
      idle(1);
      kbd_strobe = 1'b0;
      idle(5);
      rd(2'b01, 8'h84, 5, "flag A on falling edge");
      rd(2'b00, 8'h33, 5, "code latched on falling edge");

      // R4 mixed directions
      wr(2'b01, 8'h00);
      wr(2'b00, 8'hF0);
      wr(2'b01, 8'h04);
      wr(2'b00, 8'hAB);
      rd(2'b00, 8'hA3, 4, "port A mixed");
      pb_in = 7'h15;
      wr(2'b11, 8'h02);
      wr(2'b10, 8'h70);
      wr(2'b11, 8'h06);
      rd(2'b10, 8'h45, 4, "port B mixed");
      chk(pb_out, 8'h40, 8, "pb_out masked");                     // R8

      // R9 deselected access
      @(posedge phi2); #1;
      cs = 1'b0; rw = 1'b0; rs = 2'b11; din = 8'h00;
      #2 chk(dout, 8'h00, 9, "dout while deselected write");
      @(posedge phi2); #1;
      rw = 1'b1;
      #2 chk(dout, 8'h00, 9, "dout while deselected read");
      rd(2'b11, 8'h06, 9, "deselected write ignored");

      // R1 reset in mid-run
      @(posedge phi2); #1;
      rst_n = 1'b0;
      idle(1);
      rst_n = 1'b1;
      rd(2'b01, 8'h00, 1, "control A after reset");
      rd(2'b11, 8'h00, 1, "control B after reset");
      rd(2'b00, 8'h00, 1, "direction A after reset");
      rd(2'b10, 8'h00, 1, "direction B after reset");
      chk({7'h0, dsp_avail}, 8'h00, 1, "avail after reset");
      chk(pb_dir, 8'h00, 1, "pb_dir after reset");

      summary();
   end
endmodule